// File: doc/BRIEF.md
# Pulse Item Waveform Transmitter

A multi-channel waveform generator. Each channel plays back 32-bit pulse items from a shared item memory. An item holds two level/duration pairs. The channel drives its pin to the first level for the first duration, then to the second level for the second duration. Durations count ticks of a shared prescaler that divides the block clock by a run-time divider. In the intended system the reference clock is 80 MHz and the usual divider is 2, which gives 40 MHz ticks.

The item memory is built from fixed-size blocks, and each channel owns a run of consecutive blocks. Ganging more blocks per channel deepens every channel's buffer but lowers the channel count, which is the number of blocks divided by the blocks per channel. A channel plays its region as a ping-pong buffer. Each time one half has been played out, a threshold event fires so a producer can refill that half, and playback wraps from the last item back to the first.

A zero duration ends the transmission and raises a done event. While a channel is idle, its pin rests at a per-channel idle level. A per-channel ownership input decides whether the producer may write that channel's region. Threshold, done and underrun events collect in sticky status bits that are cleared by writing one, and a single interrupt output is raised from the enabled status bits.

Top module: `pulse_item_tx`

## Requirements
- R1: An item packs the first duration in bits 14:0, the first level in bit 15, the second duration in bits 30:16 and the second level in bit 31. A playing channel drives its pin to the first level for exactly the first duration in ticks, then to the second level for the second duration, then moves straight on to the next item with no gap.
- R2: One tick occurs every `clk_div` clock cycles, and a `clk_div` of 0 acts as 1. A start request takes effect at the next tick, and every phase lasts its duration multiplied by `clk_div` clock cycles.
- R3: Channel c owns item addresses c*R through c*R+R-1, where R = BLOCK_ITEMS*BLKS_PER_CH. There are NUM_BLOCKS/BLKS_PER_CH channels. Playback starts at relative index 0 and wraps from R-1 back to 0.
- R4: `thr_evt[c]` pulses for one cycle in the last cycle of an item at relative index R/2-1 or R-1, and only when that item's second phase completes.
- R5: When the next phase to play has a duration of 0, `done_evt[c]` pulses in the cycle in which that phase would begin to load and the channel returns to idle. This applies to the first duration of the item loaded at start, the second duration of the current item, and the first duration of the following item.
- R6: While a channel is idle, `busy[c]` is 0 and `pin[c]` equals `idle_lvl[c]`.
- R7: A write lands only when `own_hw` is 0 for the channel that owns the address. Otherwise the memory is left unchanged.
- R8: A half counts as refilled once any accepted write has landed in it since it was last played out. Starting a channel marks both halves refilled. Playback that continues into a half that has not been refilled raises an underrun event. A write in the same cycle as the threshold event for that half counts as a refill.
- R9: `sts` holds sticky bits: threshold in [NCH-1:0], done in [2*NCH-1:NCH] and underrun in [3*NCH-1:2*NCH]. Writing a 1 to a bit through `sts_clr` clears it, but a new event in the same cycle wins over the clear. `irq` is the OR of `sts & irq_en`.
- R10: A start request made while a channel is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (reference) |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | 8 | Tick divider, 0 treated as 1 |
| wr_en | input | 1 | Item memory write strobe |
| wr_addr | input | 9 | Item address |
| wr_data | input | 32 | Item value |
| own_hw | input | 4 | Per-channel ownership, 1 blocks writes |
| idle_lvl | input | 4 | Per-channel idle pin level |
| start | input | 4 | Per-channel start request |
| irq_en | input | 12 | Interrupt enable per status bit |
| sts_clr | input | 12 | Write-one-to-clear for status bits |
| pin | output | 4 | Waveform outputs |
| busy | output | 4 | Channel playing |
| thr_evt | output | 4 | Half-consumed event pulse |
| done_evt | output | 4 | End-of-transmission pulse |
| sts | output | 12 | Sticky status bits |
| irq | output | 1 | Combined interrupt |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a refill write and the threshold event that consumes the half being written. The bench watches for the half-0 threshold pulse and drives the refill write in that same cycle. It then expects no underrun when playback wraps, where the same run without any refill must report one. The second pair is a done event and a clear of its status bit. The bench issues the clear in the cycle the done pulse is visible and expects the bit to survive until a later clear.

// File: rtl/pit_pkg.sv
package pit_pkg;

  localparam int DUR_W = 15;

  // Item layout: second pair in the upper half, first pair in the lower half.
  typedef struct packed {
    logic             lvl1;
    logic [DUR_W-1:0] dur1;
    logic             lvl0;
    logic [DUR_W-1:0] dur0;
  } pit_item_t;

  typedef enum logic [1:0] {CH_IDLE, CH_PH0, CH_PH1} ch_state_e;

  // Effective divider: zero behaves as one.
  function automatic logic [7:0] eff_div(input logic [7:0] d);
    return (d == 8'd0) ? 8'd1 : d;
  endfunction

  // True when the item at relative index idx is the last of a half.
  function automatic logic half_last(input int idx, input int region);
    return (idx == region / 2 - 1) || (idx == region - 1);
  endfunction

endpackage

// File: rtl/pit_tick_gen.sv
module pit_tick_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] div,
  output logic       tick
);
  import pit_pkg::*;

  logic [7:0] cnt_q;
  logic [7:0] div_e;

  assign div_e = eff_div(div);
  assign tick  = (cnt_q >= div_e - 8'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 8'd1;
  end

  // R2: with a divider above one, ticks never come back to back
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_e > 8'd1) |=> (!tick || div_e != $past(div_e)));

endmodule

// File: rtl/pit_item_mem.sv
module pit_item_mem #(
  parameter int NCH   = 4,
  parameter int RI    = 128,
  parameter int AW    = 9,
  localparam int RIW  = $clog2(RI),
  localparam int DEPTH = NCH * RI
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [AW-1:0]                 wr_addr,
  input  logic [31:0]                   wr_data,
  input  logic [NCH-1:0]                own_hw,
  input  logic [NCH-1:0][AW-1:0]        rd_addr,
  output pit_pkg::pit_item_t [NCH-1:0]  rd_item,
  output logic                          wr_ok
);
  import pit_pkg::*;

  pit_item_t mem_q [DEPTH];
  int        owner;

  assign owner = int'(wr_addr >> RIW);
  assign wr_ok = wr_en && !own_hw[owner];

  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[wr_addr] <= pit_item_t'(wr_data);
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) rd_item[c] = mem_q[rd_addr[c]];
  end

  // R7: a write is never accepted for a region owned by the engine
  a_r7_owner_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && own_hw[owner]) |-> !wr_ok);

endmodule

// File: rtl/pit_channel.sv
module pit_channel #(
  parameter int RI   = 128,
  localparam int RIW = $clog2(RI),
  localparam int HALF = RI / 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               start,
  input  logic               idle_lvl,
  input  logic               ref_hit,
  input  logic               ref_half,
  input  pit_pkg::pit_item_t item,
  output logic [RIW-1:0]     rd_idx,
  output logic               pin,
  output logic               busy,
  output logic               thr_evt,
  output logic               done_evt,
  output logic               unr_evt
);
  import pit_pkg::*;

  ch_state_e        st_q;
  logic [DUR_W-1:0] cnt_q, dur1_q;
  logic             lvl_q, lvl1_q, pend_q;
  logic [RIW-1:0]   idx_q, idx_nxt;
  logic [1:0]       fresh_q, refill, fresh_now;
  logic             fin, fin0, fin1, load_go, enter_half, cur_half;

  assign busy       = (st_q != CH_IDLE);
  assign idx_nxt    = (idx_q == RIW'(RI - 1)) ? '0 : idx_q + 1'b1;
  assign rd_idx     = busy ? idx_nxt : '0;
  assign fin        = busy && tick && (cnt_q == DUR_W'(1));
  assign fin0       = fin && (st_q == CH_PH0);
  assign fin1       = fin && (st_q == CH_PH1);
  assign load_go    = !busy && tick && (pend_q || start);
  assign cur_half   = idx_q[RIW-1];
  assign enter_half = idx_nxt[RIW-1];
  assign refill     = ref_hit ? (2'b01 << ref_half) : 2'b00;
  assign fresh_now  = fresh_q | refill;

  assign thr_evt  = fin1 && half_last(int'(idx_q), RI);
  assign done_evt = (load_go && item.dur0 == '0) || (fin0 && dur1_q == '0)
                  || (fin1 && item.dur0 == '0);
  assign unr_evt  = thr_evt && (item.dur0 != '0) && !fresh_now[enter_half];
  assign pin      = busy ? lvl_q : idle_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= CH_IDLE;
      cnt_q   <= '0;
      dur1_q  <= '0;
      lvl_q   <= 1'b0;
      lvl1_q  <= 1'b0;
      pend_q  <= 1'b0;
      idx_q   <= '0;
      fresh_q <= 2'b00;
    end else begin
      fresh_q <= fresh_now;
      if (thr_evt) fresh_q[cur_half] <= refill[cur_half];
      case (st_q)
        CH_IDLE: begin
          if (load_go) begin
            pend_q  <= 1'b0;
            idx_q   <= '0;
            fresh_q <= 2'b11;
            if (item.dur0 != '0) begin
              st_q   <= CH_PH0;
              cnt_q  <= item.dur0;
              lvl_q  <= item.lvl0;
              dur1_q <= item.dur1;
              lvl1_q <= item.lvl1;
            end
          end else if (start) begin
            pend_q <= 1'b1;
          end
        end
        CH_PH0: begin
          if (fin0) begin
            if (dur1_q == '0) st_q <= CH_IDLE;
            else begin
              st_q  <= CH_PH1;
              cnt_q <= dur1_q;
              lvl_q <= lvl1_q;
            end
          end else if (tick) cnt_q <= cnt_q - DUR_W'(1);
        end
        default: begin
          if (fin1) begin
            idx_q <= idx_nxt;
            if (item.dur0 == '0) st_q <= CH_IDLE;
            else begin
              st_q   <= CH_PH0;
              cnt_q  <= item.dur0;
              lvl_q  <= item.lvl0;
              dur1_q <= item.dur1;
              lvl1_q <= item.lvl1;
            end
          end else if (tick) cnt_q <= cnt_q - DUR_W'(1);
        end
      endcase
    end
  end

  // R1: a playing phase always has ticks left to count
  a_r1_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q != '0));
  // R5: a done event leaves the channel idle
  a_r5_done_idles: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !busy);
  // R4: a threshold event moves playback onto a half boundary
  a_r4_thr_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    thr_evt |=> (idx_q == RIW'(HALF) || idx_q == '0));
  // R10: a start while busy is never held over
  a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !pend_q);

endmodule

// File: rtl/pit_status.sv
module pit_status #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_v,
  input  logic [W-1:0] clr_v,
  input  logic [W-1:0] en_v,
  output logic [W-1:0] sts,
  output logic         irq
);
  logic [W-1:0] sts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= (sts_q & ~clr_v) | set_v;
  end

  assign sts = sts_q;
  assign irq = |(sts_q & en_v);

  // R9: an event always lands in status, even against a clear
  a_r9_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (set_v != '0) |=> ((sts_q & $past(set_v)) == $past(set_v)));

endmodule

// File: rtl/pulse_item_tx.sv
module pulse_item_tx #(
  parameter int NUM_BLOCKS  = 8,
  parameter int BLOCK_ITEMS = 64,
  parameter int BLKS_PER_CH = 2,
  localparam int NCH = NUM_BLOCKS / BLKS_PER_CH,
  localparam int RI  = BLOCK_ITEMS * BLKS_PER_CH,
  localparam int RIW = $clog2(RI),
  localparam int AW  = $clog2(NUM_BLOCKS * BLOCK_ITEMS),
  localparam int SW  = 3 * NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [7:0]     clk_div,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [31:0]    wr_data,
  input  logic [NCH-1:0] own_hw,
  input  logic [NCH-1:0] idle_lvl,
  input  logic [NCH-1:0] start,
  input  logic [SW-1:0]  irq_en,
  input  logic [SW-1:0]  sts_clr,
  output logic [NCH-1:0] pin,
  output logic [NCH-1:0] busy,
  output logic [NCH-1:0] thr_evt,
  output logic [NCH-1:0] done_evt,
  output logic [SW-1:0]  sts,
  output logic           irq
);
  import pit_pkg::*;

  logic                   tick, wr_ok;
  logic [NCH-1:0][AW-1:0] rd_addr;
  pit_item_t [NCH-1:0]    rd_item;
  logic [NCH-1:0]         unr_evt;

  pit_tick_gen u_tick (
    .clk(clk), .rst_n(rst_n), .div(clk_div), .tick(tick)
  );

  pit_item_mem #(.NCH(NCH), .RI(RI), .AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .own_hw(own_hw), .rd_addr(rd_addr),
    .rd_item(rd_item), .wr_ok(wr_ok)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [RIW-1:0] rd_idx;
    logic           ref_hit;

    assign ref_hit    = wr_ok && (int'(wr_addr >> RIW) == c);
    assign rd_addr[c] = AW'(c * RI) + AW'(rd_idx);

    pit_channel #(.RI(RI)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start(start[c]),
      .idle_lvl(idle_lvl[c]), .ref_hit(ref_hit), .ref_half(wr_addr[RIW-1]),
      .item(rd_item[c]), .rd_idx(rd_idx), .pin(pin[c]), .busy(busy[c]),
      .thr_evt(thr_evt[c]), .done_evt(done_evt[c]), .unr_evt(unr_evt[c])
    );
  end

  pit_status #(.W(SW)) u_sts (
    .clk(clk), .rst_n(rst_n), .set_v({unr_evt, done_evt, thr_evt}),
    .clr_v(sts_clr), .en_v(irq_en), .sts(sts), .irq(irq)
  );

endmodule

// File: tb/tb_pulse_item_tx.sv
`timescale 1ns/1ps
module tb_pulse_item_tx;
  localparam int NB = 4, BI = 4, BPC = 2;
  localparam int NCH = NB / BPC, RI = BI * BPC, AW = $clog2(NB * BI), SW = 3 * NCH;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] clk_div = 8'd1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [NCH-1:0] own_hw = '0, idle_lvl = 2'b10, start = '0;
  logic [SW-1:0] irq_en = '1, sts_clr = '0;
  logic [NCH-1:0] pin, busy, thr_evt, done_evt;
  logic [SW-1:0] sts;
  logic irq;

  logic [31:0] model [NB*BI];
  int tests = 0, fails = 0;
  bit finished = 0;

  pulse_item_tx #(.NUM_BLOCKS(NB), .BLOCK_ITEMS(BI), .BLKS_PER_CH(BPC)) dut (.*);

  always #2.5 clk = ~clk;

  function automatic logic [31:0] mk(input bit l0, input int d0, input bit l1, input int d1);
    return {l1, 15'(d1), l0, 15'(d0)};
  endfunction

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    if (!own_hw[a / RI]) model[a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clr_all();
    sts_clr = '1; @(negedge clk); sts_clr = '0;
  endtask

  task automatic walk(input int ch);
    int idx = 0;
    logic [31:0] it, nx;
    start[ch] = 1'b1; @(posedge clk); @(negedge clk); start[ch] = 1'b0;
    for (int step = 0; step < 32; step++) begin
      int bad = 0;
      int d0, d1, nidx;
      it = model[ch*RI+idx]; d0 = int'(it[14:0]); d1 = int'(it[30:16]);
      if (d0 == 0) begin
        chk(busy[ch] == 1'b0, $sformatf("R5 stop at item %0d ch%0d", idx, ch), busy[ch], 0);
        break;
      end
      for (int k = 0; k < d0; k++) begin
        if (pin[ch] !== it[15]) bad++;
        if (k == d0 - 1)
          chk(done_evt[ch] === (d1 == 0), $sformatf("R5 done after first half ch%0d", ch),
              done_evt[ch], d1 == 0);
        @(negedge clk);
      end
      if (d1 == 0) begin
        chk(bad == 0, $sformatf("R1 item %0d ch%0d", idx, ch), bad, 0);
        chk(busy[ch] == 1'b0 && pin[ch] == idle_lvl[ch], $sformatf("R6 idle ch%0d", ch),
            pin[ch], idle_lvl[ch]);
        break;
      end
      nidx = (idx + 1) % RI; nx = model[ch*RI+nidx];
      for (int k = 0; k < d1; k++) begin
        if (pin[ch] !== it[31]) bad++;
        if (k == d1 - 1) begin
          chk(thr_evt[ch] === (idx == RI/2-1 || idx == RI-1),
              $sformatf("R4 threshold item %0d ch%0d", idx, ch), thr_evt[ch],
              idx == RI/2-1 || idx == RI-1);
          chk(done_evt[ch] === (nx[14:0] == 0), $sformatf("R5 done at item end ch%0d", ch),
              done_evt[ch], nx[14:0] == 0);
        end
        @(negedge clk);
      end
      chk(bad == 0, $sformatf("R1 item %0d ch%0d (R3 region)", idx, ch), bad, 0);
      idx = nidx;
    end
  endtask

  initial begin
    int hi, bz, thr_n, guard;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pin == idle_lvl && busy == '0, "R6 reset pins idle", pin, idle_lvl);
    chk(sts == '0 && irq == 1'b0, "R9 reset status clear", sts, 0);

    // R1/R4/R5 on channel 0, terminator after a half boundary
    wr(0, mk(1,2,0,3)); wr(1, mk(0,1,1,1)); wr(2, mk(1,4,0,1)); wr(3, mk(1,1,0,2));
    wr(4, mk(0,0,0,0));
    walk(0);
    // R3/R6 on channel 1: its own region, ends on a zero second duration
    wr(8, mk(0,3,1,2)); wr(9, mk(1,2,0,0));
    walk(1);

    // R7: write blocked while the engine owns channel 0
    own_hw = 2'b01; wr(0, mk(0,0,0,0)); own_hw = 2'b00;
    start[0] = 1'b1; @(negedge clk); start[0] = 1'b0;
    chk(busy[0] == 1'b1, "R7 blocked write left item intact", busy[0], 1);
    guard = 0; while (busy[0] && guard < 100) begin @(negedge clk); guard++; end
    wr(0, mk(0,0,0,0));
    start[0] = 1'b1; #1;
    chk(done_evt[0] == 1'b1, "R5 zero first duration at start", done_evt[0], 1);
    @(negedge clk); start[0] = 1'b0;
    chk(busy[0] == 1'b0, "R7 accepted write took effect", busy[0], 0);

    // R2 divider and R10 restart ignored
    clk_div = 8'd3; wr(0, mk(1,2,0,1)); wr(1, mk(0,0,0,0));
    start[0] = 1'b1; @(negedge clk); start[0] = 1'b0;
    hi = 0; bz = 0;
    for (int k = 0; k < 40; k++) begin
      if (k == 4) start[0] = 1'b1;
      if (k == 5) start[0] = 1'b0;
      if (pin[0]) hi++;
      if (busy[0]) bz++;
      @(negedge clk);
    end
    chk(hi == 6, "R2 first phase spans dur*div cycles", hi, 6);
    chk(bz == 9, "R10 start while busy ignored (busy length)", bz, 9);
    clk_div = 8'd0;

    // R8 underrun: no refill of half 0
    for (int i = 0; i < RI; i++) wr(i, mk(1,1,0,1));
    clr_all();
    start[0] = 1'b1; @(negedge clk); start[0] = 1'b0;
    thr_n = 0; guard = 0;
    while (thr_n < 2 && guard < 200) begin
      if (thr_evt[0]) thr_n++;
      if (thr_n < 2) @(negedge clk);
      guard++;
    end
    chk(sts[2*NCH] == 1'b0, "R8 no underrun before wrap", sts[2*NCH], 0);
    @(negedge clk);
    chk(sts[2*NCH] == 1'b1, "R8 underrun on stale half", sts[2*NCH], 1);
    wr(4, mk(0,0,0,0));
    guard = 0; while (busy[0] && guard < 100) begin @(negedge clk); guard++; end
    chk(busy[0] == 1'b0, "R5 stop after refilled terminator", busy[0], 0);

    // R8 refill in the same cycle as the threshold event
    for (int i = 0; i < RI; i++) wr(i, mk(1,1,0,1));
    clr_all();
    start[0] = 1'b1; @(negedge clk); start[0] = 1'b0;
    thr_n = 0; guard = 0; seen = 0;
    while (busy[0] && guard < 200) begin
      if (thr_evt[0]) thr_n++;
      if (done_evt[0]) begin
        seen = 1;
        sts_clr[NCH] = 1'b1; @(negedge clk); sts_clr[NCH] = 1'b0;
      end else if (thr_evt[0] && thr_n == 1) wr(1, mk(0,0,0,0));
      else @(negedge clk);
      guard++;
    end
    chk(seen == 1'b1, "R5 done after wrap", seen, 1);
    chk(thr_n == 2, "R3 wrap after last item (threshold count)", thr_n, 2);
    chk(sts[2*NCH] == 1'b0, "R8 same-cycle refill avoids underrun", sts[2*NCH], 0);
    chk(sts[NCH] == 1'b1, "R9 set wins over same-cycle clear", sts[NCH], 1);
    chk(irq == 1'b1, "R9 irq from enabled status", irq, 1);
    irq_en = '0; #1;
    chk(irq == 1'b0, "R9 irq masked", irq, 0);
    irq_en = '1;
    clr_all();
    chk(sts == '0 && irq == 1'b0, "R9 write-one clear", sts, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule